// File: doc/BRIEF.md
# Saturating Arithmetic Unit With Sticky Flag

This block is a 32-bit arithmetic datapath that produces a clamped result in the same cycle as its operands arrive. It offers signed and unsigned add and subtract that saturate at the limits of the word, a modular add that only records signed overflow, and clamping of a word to a bit width chosen at run time, either signed or unsigned. Each clamp also has a dual form that treats the two 16-bit halves of the word as separate signed values.

Each saturation event sets a single sticky flag register, but only in a cycle where the op-valid strobe is high. The flag then stays set until an explicit clear. The result path is purely combinational. The flag is the only state in the block.

Top module: `sat_unit`

## Requirements
- R1: Opcode 0 (signed add) returns a+b. When both operands share a sign and the sum's sign differs from a, it returns 0x7FFFFFFF if a is non-negative and 0x80000000 otherwise, and this counts as a saturation event.
- R2: Opcode 1 (signed subtract) returns a-b. When the operands differ in sign and the difference's sign differs from a, it returns 0x7FFFFFFF if a is non-negative and 0x80000000 otherwise, and this counts as a saturation event.
- R3: Opcode 2 (unsigned add) returns a+b. If the sum exceeds 0xFFFFFFFF it returns 0xFFFFFFFF, and this counts as a saturation event.
- R4: Opcode 3 (unsigned subtract) returns a-b. If b > a it returns 0, and this counts as a saturation event.
- R5: Opcode 4 (wrapping add) always returns (a+b) mod 2^32. A signed overflow, defined as in R1, counts as a saturation event.
- R6: Opcode 5 (signed width clamp) treats a as signed and clamps it to the range -2^n .. 2^n-1, where n = sat_n. Any value that is clamped counts as a saturation event.
- R7: Opcode 6 (unsigned width clamp) treats a as signed. A negative a gives 0, and an a above 2^n-1 gives 2^n-1. Either case counts as a saturation event.
- R8: Opcode 7 (dual signed clamp) sign-extends bits [15:0] and bits [31:16] of a and clamps each half as in R6. Each result is truncated to 16 bits and placed in the same half. A clamp in either half counts as a saturation event.
- R9: Opcode 8 (dual unsigned clamp) sign-extends bits [15:0] and bits [31:16] of a and clamps each half as in R7. Each result is truncated to 16 bits and placed in the same half. A clamp in either half counts as a saturation event.
- R10: sat_flag is 0 after reset. It is set on the clock edge after a saturation event while op_valid is 1. No operation clears it, and an event with op_valid at 0 does not set it.
- R11: When flag_clr is 1 at a clock edge, sat_flag becomes 0 even if a saturation event happens in the same cycle.
- R12: Opcodes 9 to 15 return 0 and never count as a saturation event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Qualifies the current operation for flag update |
| op | input | 4 | Operation code |
| a | input | 32 | First operand, or value to clamp |
| b | input | 32 | Second operand |
| sat_n | input | 5 | Clamp width parameter n |
| flag_clr | input | 1 | Clears the sticky flag, has priority over a set |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench aims at the word limits. It drives the most positive and most negative values through add and subtract. A wrong overflow rule here shows up as a wrapped result, or as the wrong rail when the first operand is negative. It also runs width clamps at n=0 and n=31, where an off-by-one in the mask or the shift either clamps everything or misses the lowest negative value. The dual forms are driven with the halves on opposite rails, which exposes a half that is not sign-extended or that leaks into its neighbour. A clear and an event in the same cycle, and events with op_valid low, expose the wrong priority or a flag that ignores the strobe.

// File: rtl/sat_pkg.sv
package sat_pkg;
   typedef enum logic [3:0] {
      OP_SADD   = 4'd0,
      OP_SSUB   = 4'd1,
      OP_UADD   = 4'd2,
      OP_USUB   = 4'd3,
      OP_WADD   = 4'd4,
      OP_SCLAMP = 4'd5,
      OP_UCLAMP = 4'd6,
      OP_SDUAL  = 4'd7,
      OP_UDUAL  = 4'd8
   } sat_op_e;
   localparam int unsigned OP_W = 4;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
   parameter int unsigned W   = 32,
   parameter bit          SUB = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] raw,
   output logic [W-1:0] s_rail,
   output logic         s_ovf,
   output logic         u_ovf
);
   logic [W:0] ext;

   generate
      if (SUB) begin : g_sub
         assign ext   = {1'b0, a} - {1'b0, b};
         assign s_ovf = (a[W-1] != b[W-1]) && (ext[W-1] != a[W-1]);
      end else begin : g_add
         assign ext   = {1'b0, a} + {1'b0, b};
         assign s_ovf = (a[W-1] == b[W-1]) && (ext[W-1] != a[W-1]);
      end
   endgenerate

   assign raw    = ext[W-1:0];
   assign u_ovf  = ext[W];
   assign s_rail = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
   parameter int unsigned W      = 32,
   parameter bit          SIGNED = 1'b1,
   localparam int unsigned NW    = $clog2(W)
) (
   input  logic [W-1:0]  val,
   input  logic [NW-1:0] n,
   output logic [W-1:0]  res,
   output logic          sat
);
   logic [W-1:0] mask;
   assign mask = ({{(W-1){1'b0}}, 1'b1} << n) - {{(W-1){1'b0}}, 1'b1};

   generate
      if (SIGNED) begin : g_signed
         logic signed [W-1:0] top;
         logic                above, below;
         assign top   = $signed(val) >>> n;
         assign above = (top > 0);
         assign below = (top < -1);
         assign sat   = above | below;
         assign res   = above ? mask : (below ? ~mask : val);
      end else begin : g_unsigned
         logic neg, big;
         assign neg = val[W-1];
         assign big = !neg && (val > mask);
         assign sat = neg | big;
         assign res = neg ? '0 : (big ? mask : val);
      end
   endgenerate
endmodule

// File: rtl/sat_unit.sv
module sat_unit
   import sat_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned HALF_W = DATA_W / 2,
   localparam int unsigned N_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [N_W-1:0]    sat_n,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] result,
   output logic              sat_flag
);
   generate
      if (DATA_W % 2 != 0 || DATA_W < 8) begin : g_bad_width
         $error("sat_unit: DATA_W must be even and at least 8");
      end
      if ((1 << N_W) != DATA_W) begin : g_bad_pow2
         $error("sat_unit: DATA_W must be a power of two");
      end
   endgenerate

   // Add (index 0) and subtract (index 1) lanes
   logic [DATA_W-1:0] as_raw  [2];
   logic [DATA_W-1:0] as_rail [2];
   logic              as_sov  [2];
   logic              as_uov  [2];

   generate
      for (genvar k = 0; k < 2; k++) begin : g_as
         sat_addsub #(.W(DATA_W), .SUB(k == 1)) u_as (
            .a(a), .b(b), .raw(as_raw[k]), .s_rail(as_rail[k]),
            .s_ovf(as_sov[k]), .u_ovf(as_uov[k])
         );
      end
   endgenerate

   // Word clamps (index 0 signed, 1 unsigned) and half clamps [kind][half]
   logic [DATA_W-1:0] w_res [2];
   logic              w_sat [2];
   logic [DATA_W-1:0] h_res [2][2];
   logic              h_sat [2][2];

   generate
      for (genvar s = 0; s < 2; s++) begin : g_kind
         sat_clamp #(.W(DATA_W), .SIGNED(s == 0)) u_word (
            .val(a), .n(sat_n), .res(w_res[s]), .sat(w_sat[s])
         );
         for (genvar h = 0; h < 2; h++) begin : g_half
            logic [HALF_W-1:0] part;
            assign part = a[h*HALF_W +: HALF_W];
            sat_clamp #(.W(DATA_W), .SIGNED(s == 0)) u_half (
               .val({{HALF_W{part[HALF_W-1]}}, part}), .n(sat_n),
               .res(h_res[s][h]), .sat(h_sat[s][h])
            );
         end
      end
   endgenerate

   logic event_hit;

   always_comb begin
      result    = '0;
      event_hit = 1'b0;
      case (sat_op_e'(op))
         OP_SADD: begin
            result    = as_sov[0] ? as_rail[0] : as_raw[0];
            event_hit = as_sov[0];
         end
         OP_SSUB: begin
            result    = as_sov[1] ? as_rail[1] : as_raw[1];
            event_hit = as_sov[1];
         end
         OP_UADD: begin
            result    = as_uov[0] ? '1 : as_raw[0];
            event_hit = as_uov[0];
         end
         OP_USUB: begin
            result    = as_uov[1] ? '0 : as_raw[1];
            event_hit = as_uov[1];
         end
         OP_WADD: begin
            result    = as_raw[0];
            event_hit = as_sov[0];
         end
         OP_SCLAMP: begin
            result    = w_res[0];
            event_hit = w_sat[0];
         end
         OP_UCLAMP: begin
            result    = w_res[1];
            event_hit = w_sat[1];
         end
         OP_SDUAL: begin
            result    = {h_res[0][1][HALF_W-1:0], h_res[0][0][HALF_W-1:0]};
            event_hit = h_sat[0][0] | h_sat[0][1];
         end
         OP_UDUAL: begin
            result    = {h_res[1][1][HALF_W-1:0], h_res[1][0][HALF_W-1:0]};
            event_hit = h_sat[1][0] | h_sat[1][1];
         end
         default: begin
            result    = '0;
            event_hit = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     sat_flag <= 1'b0;
      else if (flag_clr)              sat_flag <= 1'b0;
      else if (op_valid && event_hit) sat_flag <= 1'b1;
   end

   p_clr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> !sat_flag);
   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !flag_clr) |=> sat_flag);
   p_idle_no_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_flag && !op_valid) |=> !sat_flag);
   p_usub_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_USUB && a < b) |-> result == '0);
   p_uadd_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_UADD && ({1'b0, a} + {1'b0, b}) > {1'b0, {DATA_W{1'b1}}}) |-> result == '1);
   p_sadd_rail_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SADD && a[DATA_W-1] == b[DATA_W-1]) |-> result[DATA_W-1] == a[DATA_W-1]);
   p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (op > OP_UDUAL) |-> result == '0);
endmodule

// File: tb/tb_sat_unit.sv
module tb_sat_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] a = '0, b = '0;
   logic [4:0]  sat_n = '0;
   logic        flag_clr = 1'b0;
   logic [31:0] result;
   logic        sat_flag;

   int checks = 0, errors = 0;
   bit flag_model = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sat_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .a(a), .b(b),
      .sat_n(sat_n), .flag_clr(flag_clr), .result(result), .sat_flag(sat_flag)
   );

   function automatic string req_of(int o);
      case (o)
         0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
         4: return "R5";  5: return "R6";  6: return "R7";  7: return "R8";
         8: return "R9";  default: return "R12";
      endcase
   endfunction

   function automatic longint clamp_s(longint v, int n, output bit ev);
      longint hi = (64'sd1 <<< n) - 1;
      longint lo = -(64'sd1 <<< n);
      ev = 1'b0;
      if (v > hi) begin ev = 1'b1; return hi; end
      if (v < lo) begin ev = 1'b1; return lo; end
      return v;
   endfunction

   function automatic longint clamp_u(longint v, int n, output bit ev);
      longint hi = (64'sd1 <<< n) - 1;
      ev = 1'b0;
      if (v < 0)  begin ev = 1'b1; return 0; end
      if (v > hi) begin ev = 1'b1; return hi; end
      return v;
   endfunction

   function automatic logic [31:0] ref_res(int o, logic [31:0] x, logic [31:0] y,
                                           int n, output bit ev);
      longint sx = longint'($signed(x));
      longint sy = longint'($signed(y));
      longint ux = longint'({32'd0, x});
      longint uy = longint'({32'd0, y});
      longint t, lo16, hi16;
      bit e0, e1;
      ev = 1'b0;
      case (o)
         0: begin t = sx + sy; t = clamp_s(t, 31, ev); return t[31:0]; end
         1: begin t = sx - sy; t = clamp_s(t, 31, ev); return t[31:0]; end
         2: begin t = ux + uy; if (t > 64'hFFFFFFFF) begin ev = 1; return 32'hFFFFFFFF; end return t[31:0]; end
         3: begin if (uy > ux) begin ev = 1; return 0; end t = ux - uy; return t[31:0]; end
         4: begin t = sx + sy; ev = (t > 64'sd2147483647) || (t < -64'sd2147483648); return t[31:0]; end
         5: begin t = clamp_s(sx, n, ev); return t[31:0]; end
         6: begin t = clamp_u(sx, n, ev); return t[31:0]; end
         7, 8: begin
            lo16 = longint'($signed(x[15:0]));
            hi16 = longint'($signed(x[31:16]));
            if (o == 7) begin lo16 = clamp_s(lo16, n, e0); hi16 = clamp_s(hi16, n, e1); end
            else        begin lo16 = clamp_u(lo16, n, e0); hi16 = clamp_u(hi16, n, e1); end
            ev = e0 | e1;
            return {hi16[15:0], lo16[15:0]};
         end
         default: return 0;
      endcase
   endfunction

   task automatic run(int o, logic [31:0] x, logic [31:0] y, int n, bit v, bit c);
      logic [31:0] exp_r;
      bit ev;
      @(negedge clk);
      op = o[3:0]; a = x; b = y; sat_n = n[4:0]; op_valid = v; flag_clr = c;
      exp_r = ref_res(o, x, y, n, ev);
      #1;
      checks++;
      if (result !== exp_r) begin
         errors++;
         $display("FAIL %s op=%0d a=%h b=%h n=%0d result actual=%h expected=%h",
                  req_of(o), o, x, y, n, result, exp_r);
      end
      if (c) flag_model = 1'b0;
      else if (v && ev) flag_model = 1'b1;
      @(posedge clk); #1;
      checks++;
      if (sat_flag !== flag_model) begin
         errors++;
         $display("FAIL %s/R10/R11 flag after op=%0d v=%0d clr=%0d actual=%0d expected=%0d",
                  req_of(o), o, v, c, sat_flag, flag_model);
      end
   endtask

   task automatic clr();
      run(15, 0, 0, 0, 1'b0, 1'b1);
   endtask

   function automatic logic [31:0] pick();
      case ($urandom % 6)
         0: return 32'h7FFFFFFF;
         1: return 32'h80000000;
         2: return 32'hFFFFFFFF;
         3: return $urandom % 70000;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (sat_flag !== 1'b0) begin
         errors++;
         $display("FAIL R10 reset flag actual=%0d expected=0", sat_flag);
      end
      rst_n = 1'b1;

      // R1 signed add rails
      clr(); run(0, 32'h7FFFFFFF, 32'h1, 0, 1, 0);
      clr(); run(0, 32'h80000000, 32'hFFFFFFFF, 0, 1, 0);
      run(0, 32'h5, 32'hFFFFFFFD, 0, 1, 0);
      // R2 signed subtract rails
      clr(); run(1, 32'h80000000, 32'h1, 0, 1, 0);
      clr(); run(1, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 1, 0);
      // R3 / R4 unsigned
      clr(); run(2, 32'hFFFFFFFF, 32'h1, 0, 1, 0);
      clr(); run(3, 32'h0, 32'h1, 0, 1, 0);
      // R5 wrapping add sets flag, keeps modular sum
      clr(); run(4, 32'h7FFFFFFF, 32'h1, 0, 1, 0);
      // R6 / R7 width clamps incl. n=0 and n=31
      clr(); run(5, 32'd200, 0, 7, 1, 0);
      run(5, 32'hFFFFFED4, 0, 7, 1, 0);
      clr(); run(5, 32'h80000000, 0, 31, 1, 0);
      run(5, 32'h1, 0, 0, 1, 0);
      clr(); run(6, 32'd5, 0, 0, 1, 0);
      clr(); run(6, 32'h80000000, 0, 31, 1, 0);
      run(6, 32'h7FFFFFFF, 0, 31, 1, 0);
      // R8 / R9 dual halves on opposite rails
      clr(); run(7, 32'h7FFF8000, 0, 7, 1, 0);
      clr(); run(8, 32'h8000_00FF, 0, 4, 1, 0);
      clr(); run(8, 32'h0003_0002, 0, 4, 1, 0);
      // R10 event with op_valid low does not set; no op clears
      clr(); run(0, 32'h7FFFFFFF, 32'h1, 0, 0, 0);
      run(2, 32'hFFFFFFFF, 32'h5, 0, 1, 0);
      run(2, 32'h1, 32'h1, 0, 1, 0);
      // R11 clear wins over same-cycle event
      run(3, 32'h0, 32'h9, 0, 1, 1);
      // R12 unused opcodes
      run(9, 32'h7FFFFFFF, 32'h7FFFFFFF, 3, 1, 0);
      run(14, 32'hFFFFFFFF, 32'h1, 0, 1, 0);

      for (int i = 0; i < 600; i++) begin
         run($urandom % 11, pick(), pick(), $urandom % 32,
             ($urandom % 8) != 0, ($urandom % 12) == 0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule